// File: doc/BRIEF.md
# Condition-Code Shadow Register Controller

This block keeps a 16-bit status word and a 16-bit shadow word that software can write. It moves the four condition-code flags between the two words so that an interrupt routine can save the caller's flags and put them back later. A decoder outside the block sends one strobe for each instruction that affects the flag path:

- write the shadow word from a general register,
- set the transfer enable,
- clear the transfer enable,
- read the status word.

An ALU outside the block reports flag updates on a separate port.

Each rising clock edge ends one instruction cycle. The clock has two phases, and the block models them as an ordered pair of steps inside that cycle:

1. In the high phase, the status word may take the flags from the shadow word.
2. In the falling phase, the shadow word may take the flags back from the status word, using the value the status word has after step 1.

Because of this ordering, a set-enable command placed right after a shadow write restores the written flags. If any other instruction falls between the two while the enable is active, the written flags are overwritten with the old status flags. Software avoids that loss by clearing the enable before it writes the shadow word.

Top module: `ccsr_ctrl`

## Requirements
- R1: After reset, the status word and the shadow word are 0 and the transfer enable output is 1.
- R2: A legal write-shadow strobe loads the whole shadow word from `gpr_i` at the clock edge. In that cycle no flag feedback reaches the shadow word.
- R3: In a cycle with no command strobe and the enable active, the shadow flag field after the edge equals the status flag field after the same edge. The lower 12 shadow bits are unchanged. The flags occupy bits 15..12 in the order C (15), P (14), Z (13), N (12).
- R4: A legal set-enable strobe copies shadow bits 15..12 into status bits 15..12 and makes the enable 1 after the edge. The shadow word then holds the same flags.
- R5: A write-shadow in one cycle followed at once by a set-enable leaves the written flags in the status word.
- R6: If a cycle without a command strobe falls between the write-shadow and the set-enable while the enable is active, the old status flags replace the written shadow flags. The set-enable then returns those old flags to the status word.
- R7: A legal clear-enable strobe makes the enable 0. While the enable is 0, the shadow word changes only on a write-shadow. A later set-enable restores the written flags no matter how many cycles came between.
- R8: `rd_data_o` equals the status word while `rd_stat_i` is 1 and is 0 otherwise.
- R9: An ALU flag update (`alu_we_i`) writes `alu_flags_i` (bit 3 = C, bit 0 = N) into status bits 15..12 at the edge. A set-enable in the same cycle takes priority over the ALU update.
- R10: If more than one of the write-shadow, set-enable and clear-enable strobes is 1, `strobe_err_o` is 1 in that cycle and the status word, shadow word and enable stay unchanged, ALU update included.
- R11: Status bits 11..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock; one rising edge ends each cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sw_i | input | 1 | Write the shadow word from `gpr_i` |
| cc_on_i | input | 1 | Set the transfer enable and latch the shadow flags into status |
| cc_off_i | input | 1 | Clear the transfer enable |
| rd_stat_i | input | 1 | Status read strobe |
| gpr_i | input | 16 | General-register value for a shadow write |
| alu_we_i | input | 1 | ALU flag update valid |
| alu_flags_i | input | 4 | ALU flags {C,P,Z,N} |
| status_o | output | 16 | Current status word |
| shadow_o | output | 16 | Current shadow word |
| rd_data_o | output | 16 | Status read data, 0 when not reading |
| xfer_en_o | output | 1 | Current transfer enable |
| strobe_err_o | output | 1 | More than one command strobe asserted this cycle |

## Verification
A wrong enable value does not show at once. It appears one cycle after the next strobe-free instruction, as shadow flags that either copy the status flags when they should not or fail to copy them when they should. A wrong phase order only appears on `status_o` on the cycle after a set-enable, and the vector walk is built to catch it there. The walk covers both a back-to-back restore and a restore with another instruction in between, with the enable on and with it off. Any error in the ALU-versus-latch priority shows on the very next edge.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_WRSW  = 2'd1,
    CMD_CCON  = 2'd2,
    CMD_CCOFF = 2'd3
  } cmd_e;

  // true when two or more of the three command strobes are raised
  function automatic logic strobe_clash(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // single-strobe decode; a clash maps to no command
  function automatic cmd_e decode_cmd(input logic wr, input logic on, input logic off);
    if (strobe_clash(wr, on, off)) return CMD_NONE;
    if (wr)  return CMD_WRSW;
    if (on)  return CMD_CCON;
    if (off) return CMD_CCOFF;
    return CMD_NONE;
  endfunction

  // high-phase flag choice: latch from shadow wins over ALU
  function automatic logic [3:0] pick_status_flags(input cmd_e cmd, input logic [3:0] cur,
                                                   input logic [3:0] shd, input logic alu_we,
                                                   input logic [3:0] alu);
    if (cmd == CMD_CCON) return shd;
    if (alu_we)          return alu;
    return cur;
  endfunction

endpackage

// File: rtl/ccsr_strobe_guard.sv
module ccsr_strobe_guard
  import ccsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_sw,
  input  logic cc_on,
  input  logic cc_off,
  output cmd_e cmd,
  output logic clash
);

  assign clash = strobe_clash(wr_sw, cc_on, cc_off);
  assign cmd   = decode_cmd(wr_sw, cc_on, cc_off);

  // R10: a clash never produces a command
  a_r10_clash_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (cmd == CMD_NONE));

endmodule

// File: rtl/ccsr_enable_latch.sv
module ccsr_enable_latch
  import ccsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  output logic en_q,
  output logic fb_en
);

  always_ff @(posedge clk) begin
    if (!rst_n)                en_q <= 1'b1;
    else if (cmd == CMD_CCON)  en_q <= 1'b1;
    else if (cmd == CMD_CCOFF) en_q <= 1'b0;
  end

  // feedback enable for the falling phase of this cycle
  always_comb begin
    unique case (cmd)
      CMD_CCON:  fb_en = 1'b1;
      CMD_CCOFF: fb_en = 1'b0;
      default:   fb_en = en_q;
    endcase
  end

  a_r4_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CCON) |=> en_q);
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CCOFF) |=> !en_q);

endmodule

// File: rtl/ccsr_status_reg.sv
module ccsr_status_reg
  import ccsr_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  cmd_e              cmd,
  input  logic [FLAG_W-1:0] shd_flags,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] flags_nx
);

  always_comb begin
    if (hold) flags_nx = flags_q;
    else      flags_nx = pick_status_flags(cmd, flags_q, shd_flags, alu_we, alu_flags);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nx;
  end

  a_r4_latch_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cmd == CMD_CCON) |=> (flags_q == $past(shd_flags)));
  a_r9_alu_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cmd != CMD_CCON && alu_we) |=> (flags_q == $past(alu_flags)));

endmodule

// File: rtl/ccsr_shadow_reg.sv
module ccsr_shadow_reg
  import ccsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] gpr,
  input  logic              fb_en,
  input  logic [FLAG_W-1:0] st_flags_nx,
  output logic [DATA_W-1:0] word_q
);

  localparam int LO_W = DATA_W - FLAG_W;

  logic [DATA_W-1:0] word_nx;

  always_comb begin
    word_nx = word_q;
    if (!hold) begin
      if (cmd == CMD_WRSW) word_nx = gpr;
      else if (fb_en)      word_nx = {st_flags_nx, word_q[LO_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_nx;
  end

  a_r2_write_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cmd == CMD_WRSW) |=> (word_q == $past(gpr)));
  a_r3_feedback_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cmd == CMD_NONE) |=> $stable(word_q[LO_W-1:0]));
  a_r7_no_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !fb_en && cmd != CMD_WRSW) |=> $stable(word_q));

endmodule

// File: rtl/ccsr_ctrl.sv
module ccsr_ctrl
  import ccsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sw_i,
  input  logic              cc_on_i,
  input  logic              cc_off_i,
  input  logic              rd_stat_i,
  input  logic [DATA_W-1:0] gpr_i,
  input  logic              alu_we_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] shadow_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              xfer_en_o,
  output logic              strobe_err_o
);

  localparam int LO_W = DATA_W - FLAG_W;

  cmd_e              cmd;
  logic              clash;
  logic              en_q;
  logic              fb_en;
  logic [FLAG_W-1:0] st_flags_q;
  logic [FLAG_W-1:0] st_flags_nx;
  logic [DATA_W-1:0] shd_q;

  ccsr_strobe_guard u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sw  (wr_sw_i),
    .cc_on  (cc_on_i),
    .cc_off (cc_off_i),
    .cmd    (cmd),
    .clash  (clash)
  );

  ccsr_enable_latch u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .en_q  (en_q),
    .fb_en (fb_en)
  );

  ccsr_status_reg #(.FLAG_W(FLAG_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (clash),
    .cmd       (cmd),
    .shd_flags (shd_q[DATA_W-1:LO_W]),
    .alu_we    (alu_we_i),
    .alu_flags (alu_flags_i),
    .flags_q   (st_flags_q),
    .flags_nx  (st_flags_nx)
  );

  ccsr_shadow_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (clash),
    .cmd         (cmd),
    .gpr         (gpr_i),
    .fb_en       (fb_en),
    .st_flags_nx (st_flags_nx),
    .word_q      (shd_q)
  );

  assign status_o     = {st_flags_q, {LO_W{1'b0}}};
  assign shadow_o     = shd_q;
  assign rd_data_o    = rd_stat_i ? status_o : '0;
  assign xfer_en_o    = en_q;
  assign strobe_err_o = clash;

  a_r10_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err_o |=> ($stable(status_o) && $stable(shadow_o) && $stable(xfer_en_o)));
  a_r3_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en_o && !wr_sw_i && !cc_on_i && !cc_off_i)
      |=> (shadow_o[DATA_W-1:LO_W] == status_o[DATA_W-1:LO_W]));
  a_r11_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[LO_W-1:0] == '0);

endmodule

// File: tb/ccsr_ctrl_bench.sv
module ccsr_ctrl_bench;

  typedef struct packed {
    logic        wr;
    logic        on;
    logic        off;
    logic        awe;
    logic [3:0]  af;
    logic [15:0] gpr;
    logic        xerr;
    logic [15:0] xst;
    logic [15:0] xsh;
    logic        xen;
    logic [7:0]  req;
  } vec_t;

  // rows run in order from reset; expected values are after the edge
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,4'h0,16'hA5C3,1'b0,16'h0000,16'hA5C3,1'b1,8'd2},  // R2 write
    '{1'b0,1'b1,1'b0,1'b0,4'h0,16'h0000,1'b0,16'hA000,16'hA5C3,1'b1,8'd5},  // R5 restore
    '{1'b0,1'b0,1'b0,1'b1,4'h3,16'h0000,1'b0,16'h3000,16'h35C3,1'b1,8'd3},  // R3 feedback
    '{1'b1,1'b0,1'b0,1'b0,4'h0,16'hC00F,1'b0,16'h3000,16'hC00F,1'b1,8'd2},
    '{1'b0,1'b0,1'b0,1'b0,4'h0,16'h0000,1'b0,16'h3000,16'h300F,1'b1,8'd6},  // R6 clobber
    '{1'b0,1'b1,1'b0,1'b0,4'h0,16'h0000,1'b0,16'h3000,16'h300F,1'b1,8'd6},
    '{1'b0,1'b0,1'b1,1'b0,4'h0,16'h0000,1'b0,16'h3000,16'h300F,1'b0,8'd7},  // R7 off
    '{1'b1,1'b0,1'b0,1'b0,4'h0,16'h9ABC,1'b0,16'h3000,16'h9ABC,1'b0,8'd7},
    '{1'b0,1'b0,1'b0,1'b1,4'h5,16'h0000,1'b0,16'h5000,16'h9ABC,1'b0,8'd7},
    '{1'b0,1'b0,1'b0,1'b0,4'h0,16'h0000,1'b0,16'h5000,16'h9ABC,1'b0,8'd7},
    '{1'b0,1'b1,1'b0,1'b1,4'hF,16'h0000,1'b0,16'h9000,16'h9ABC,1'b1,8'd9},  // R9 priority
    '{1'b0,1'b0,1'b0,1'b1,4'h6,16'h0000,1'b0,16'h6000,16'h6ABC,1'b1,8'd9},
    '{1'b1,1'b1,1'b0,1'b1,4'h1,16'hFFFF,1'b1,16'h6000,16'h6ABC,1'b1,8'd10}, // R10 clash
    '{1'b0,1'b1,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h6000,16'h6ABC,1'b1,8'd10},
    '{1'b0,1'b0,1'b1,1'b0,4'h0,16'h0000,1'b0,16'h6000,16'h6ABC,1'b0,8'd7},
    '{1'b1,1'b0,1'b1,1'b1,4'h2,16'h0000,1'b1,16'h6000,16'h6ABC,1'b0,8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, on = 1'b0, off = 1'b0, rd = 1'b0, awe = 1'b0;
  logic [15:0] gpr = '0;
  logic [3:0]  af = '0;
  logic [15:0] st, sh, rdd;
  logic        en, err;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  ccsr_ctrl u_ccsr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_sw_i(wr), .cc_on_i(on), .cc_off_i(off),
    .rd_stat_i(rd), .gpr_i(gpr), .alu_we_i(awe), .alu_flags_i(af),
    .status_o(st), .shadow_o(sh), .rd_data_o(rdd), .xfer_en_o(en), .strobe_err_o(err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr = 0; on = 0; off = 0; awe = 0; af = '0; gpr = '0;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state; R11 low bits zero
    chk("R1 status", st, 16'h0000);
    chk("R1 shadow", sh, 16'h0000);
    chk("R1 enable", {15'd0, en}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      wr = TBL[i].wr; on = TBL[i].on; off = TBL[i].off;
      awe = TBL[i].awe; af = TBL[i].af; gpr = TBL[i].gpr;
      #1;
      chk($sformatf("R%0d err row%0d", TBL[i].req, i), {15'd0, err}, {15'd0, TBL[i].xerr});
      @(negedge clk);
      chk($sformatf("R%0d status row%0d", TBL[i].req, i), st, TBL[i].xst);
      chk($sformatf("R%0d shadow row%0d", TBL[i].req, i), sh, TBL[i].xsh);
      chk($sformatf("R%0d enable row%0d", TBL[i].req, i), {15'd0, en}, {15'd0, TBL[i].xen});
      chk($sformatf("R11 low row%0d", i), {4'd0, st[11:0]}, 16'd0);
    end
    idle();

    // R8 read path
    rd = 1'b1; #1;
    chk("R8 read on", rdd, 16'h6000);
    rd = 1'b0; #1;
    chk("R8 read off", rdd, 16'h0000);

    // R7 long gap with enable off, then restore
    @(negedge clk);
    wr = 1; gpr = 16'h5123; @(negedge clk); idle();
    awe = 1; af = 4'hA; @(negedge clk); idle();
    repeat (5) @(negedge clk);
    chk("R7 shadow held", sh, 16'h5123);
    on = 1; @(negedge clk); idle();
    chk("R7 restored", st, 16'h5000);
    chk("R4 enable set", {15'd0, en}, 16'd1);

    // R1 reset mid-run
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R1 rerun status", st, 16'h0000);
    chk("R1 rerun shadow", sh, 16'h0000);
    chk("R1 rerun enable", {15'd0, en}, 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule